// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block sits right after the instruction fetch in a small in-order integer core. The fetch stage passes it two things: the current program counter and a six-byte window of instruction memory that starts at that address. Byte 0 of the window sits in bits [7:0] and each later byte sits eight bits higher. From these the block works out, in pure combinational logic, how long the instruction is and which of four encoding shapes it has. It then pulls out the fields that the later stages need.

Those fields are the operation and variant nibbles, the two register identifiers, and the 32-bit little-endian constant, placed according to the shape. The block also gives the address of the following instruction. It reports a status code for the fetched instruction, which tells the core to continue, to stop because of a halt, to fault because of an unknown operation, or to fault because the fetch address was bad.

The block has no clock and no reset. Every output depends only on the present inputs.

Top module: `insn_fetch_decode`

## Requirements
- R1: The length output depends only on the operation nibble (bits [7:4] of byte 0). It is 1 for operations 0x0, 0x1 and 0x9. It is 2 for 0x2, 0x6, 0xA and 0xB. It is 5 for 0x7 and 0x8. It is 6 for 0x3, 0x4 and 0x5. It is 1 for any operation above 0xB.
- R2: The operation output equals bits [7:4] of byte 0, and the variant output equals bits [3:0] of byte 0, for every opcode.
- R3: For operations 0x2, 0x3, 0x4, 0x5, 0x6, 0xA and 0xB, the first register output equals bits [7:4] of byte 1 and the second equals bits [3:0] of byte 1. These values pass through as encoded, including 0xF.
- R4: For every operation without a register byte (0x0, 0x1, 0x7, 0x8, 0x9 and invalid ones), both register outputs are 0xF.
- R5: For operations 0x7 and 0x8, the constant is bytes 1 to 4 taken little-endian, with byte 1 as the least significant.
- R6: For operations 0x3, 0x4 and 0x5, the constant is bytes 2 to 5 taken little-endian, with byte 2 as the least significant.
- R7: For every operation whose length is 1 or 2, the constant output is zero, whatever the unused window bytes hold.
- R8: The next address equals the program counter plus the length, modulo 2^32.
- R9: The invalid flag is 1 exactly when the operation nibble is above 0xB.
- R10: The status codes are 0 = continue, 1 = halt, 2 = bad fetch address, 3 = invalid operation. When the fetch-error input is 0, the status is 3 for an invalid operation, 1 for operation 0x1, and 0 for everything else.
- R11: When the fetch-error input is 1, the status is 2 whatever the window holds. The invalid flag still follows R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_i | input | 32 | Address of byte 0 of the window |
| win_i | input | 48 | Instruction bytes; byte k sits at bits [8k+7:8k] |
| fetch_err_i | input | 1 | Fetch address was out of range |
| icode_o | output | 4 | Operation nibble |
| ifun_o | output | 4 | Variant nibble |
| ra_o | output | 4 | First register identifier, 0xF when absent |
| rb_o | output | 4 | Second register identifier, 0xF when absent |
| imm_o | output | 32 | Little-endian constant, zero when absent |
| len_o | output | 3 | Instruction length in bytes |
| next_pc_o | output | 32 | Address of the following instruction |
| bad_op_o | output | 1 | Operation nibble is not defined |
| stat_o | output | 2 | Status code (0 ok, 1 halt, 2 bad address, 3 bad operation) |

## Verification
The assertions hold for every combination of inputs. They check that the length is always one of the four legal values, and that register outputs and the constant are forced to their idle values whenever the shape has no such field. They also check that a fetch error always wins the status, and that an invalid operation gives the invalid status when there is no fetch error.

The following can only be shown by the bench's vectors and directed cases:
- the exact byte positions of the constant in each shape, including sign-looking high bytes;
- register fields passing through as encoded;
- the next address wrapping at the top of the address space;
- the halt status for operation 0x1.

// File: rtl/ifd_pkg.sv
package ifd_pkg;

    localparam int NIB_W = 4;

    typedef enum logic [3:0] {
        OP_NOP   = 4'h0,
        OP_HALT  = 4'h1,
        OP_RRMOV = 4'h2,
        OP_IRMOV = 4'h3,
        OP_RMMOV = 4'h4,
        OP_MRMOV = 4'h5,
        OP_ALU   = 4'h6,
        OP_JCC   = 4'h7,
        OP_CALL  = 4'h8,
        OP_RET   = 4'h9,
        OP_PUSH  = 4'hA,
        OP_POP   = 4'hB
    } opc_e;

    // Encoding shapes
    typedef enum logic [1:0] {
        FMT_BARE     = 2'd0,  // opcode byte only
        FMT_REG      = 2'd1,  // opcode + register byte
        FMT_DEST     = 2'd2,  // opcode + constant
        FMT_REGCONST = 2'd3   // opcode + register byte + constant
    } fmt_e;

    typedef enum logic [1:0] {
        ST_OK   = 2'd0,
        ST_HALT = 2'd1,
        ST_ADR  = 2'd2,
        ST_INS  = 2'd3
    } stat_e;

    localparam logic [NIB_W-1:0] NO_REG = 4'hF;

endpackage

// File: rtl/ifd_len_dec.sv
module ifd_len_dec
    import ifd_pkg::*;
#(
    parameter int CONST_BYTES = 4,
    localparam int MAX_LEN = CONST_BYTES + 2,
    localparam int LEN_W = $clog2(MAX_LEN + 1)
) (
    input  logic [NIB_W-1:0] icode_i,
    output fmt_e             fmt_o,
    output logic [LEN_W-1:0] len_o,
    output logic             has_reg_o,
    output logic             has_const_o
);

    always_comb begin
        unique case (icode_i)
            OP_RRMOV, OP_ALU, OP_PUSH, OP_POP: fmt_o = FMT_REG;
            OP_JCC, OP_CALL:                   fmt_o = FMT_DEST;
            OP_IRMOV, OP_RMMOV, OP_MRMOV:      fmt_o = FMT_REGCONST;
            default:                           fmt_o = FMT_BARE;
        endcase
    end

    always_comb begin
        has_reg_o   = (fmt_o == FMT_REG) || (fmt_o == FMT_REGCONST);
        has_const_o = (fmt_o == FMT_DEST) || (fmt_o == FMT_REGCONST);
        len_o = LEN_W'(1 + (has_reg_o ? 1 : 0) + (has_const_o ? CONST_BYTES : 0));
    end

endmodule

// File: rtl/ifd_field_ext.sv
module ifd_field_ext
    import ifd_pkg::*;
#(
    parameter int CONST_BYTES = 4,
    localparam int WIN_BYTES = CONST_BYTES + 2,
    localparam int CONST_W = CONST_BYTES * 8
) (
    input  logic [WIN_BYTES*8-1:0] win_i,
    input  logic                   has_reg_i,
    input  logic                   has_const_i,
    output logic [NIB_W-1:0]       ra_o,
    output logic [NIB_W-1:0]       rb_o,
    output logic [CONST_W-1:0]     imm_o
);

    logic [7:0] reg_byte;
    assign reg_byte = win_i[15:8];

    always_comb begin
        ra_o = has_reg_i ? reg_byte[7:4] : NO_REG;
        rb_o = has_reg_i ? reg_byte[3:0] : NO_REG;
    end

    // The constant starts one byte later when a register byte is present
    for (genvar k = 0; k < CONST_BYTES; k++) begin : g_cbyte
        logic [7:0] sel;
        assign sel = has_reg_i ? win_i[(k+2)*8 +: 8] : win_i[(k+1)*8 +: 8];
        assign imm_o[k*8 +: 8] = has_const_i ? sel : 8'h00;
    end

endmodule

// File: rtl/ifd_stat_gen.sv
module ifd_stat_gen
    import ifd_pkg::*;
(
    input  logic [NIB_W-1:0] icode_i,
    input  logic             fetch_err_i,
    output stat_e            stat_o,
    output logic             bad_op_o
);

    assign bad_op_o = (icode_i > OP_POP);

    always_comb begin
        if (fetch_err_i)                stat_o = ST_ADR;
        else if (bad_op_o)              stat_o = ST_INS;
        else if (icode_i == OP_HALT)    stat_o = ST_HALT;
        else                            stat_o = ST_OK;
    end

endmodule

// File: rtl/insn_fetch_decode.sv
module insn_fetch_decode
    import ifd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CONST_BYTES = 4,
    localparam int WIN_BYTES = CONST_BYTES + 2,
    localparam int CONST_W = CONST_BYTES * 8,
    localparam int LEN_W = $clog2(WIN_BYTES + 1)
) (
    input  logic [ADDR_W-1:0]      pc_i,
    input  logic [WIN_BYTES*8-1:0] win_i,
    input  logic                   fetch_err_i,
    output logic [3:0]             icode_o,
    output logic [3:0]             ifun_o,
    output logic [3:0]             ra_o,
    output logic [3:0]             rb_o,
    output logic [CONST_W-1:0]     imm_o,
    output logic [LEN_W-1:0]       len_o,
    output logic [ADDR_W-1:0]      next_pc_o,
    output logic                   bad_op_o,
    output logic [1:0]             stat_o
);

    fmt_e  fmt;
    logic  has_reg, has_const;
    stat_e stat;

    assign icode_o = win_i[7:4];
    assign ifun_o  = win_i[3:0];

    ifd_len_dec #(.CONST_BYTES(CONST_BYTES)) u_len (
        .icode_i     (icode_o),
        .fmt_o       (fmt),
        .len_o       (len_o),
        .has_reg_o   (has_reg),
        .has_const_o (has_const)
    );

    ifd_field_ext #(.CONST_BYTES(CONST_BYTES)) u_fld (
        .win_i       (win_i),
        .has_reg_i   (has_reg),
        .has_const_i (has_const),
        .ra_o        (ra_o),
        .rb_o        (rb_o),
        .imm_o       (imm_o)
    );

    ifd_stat_gen u_stat (
        .icode_i     (icode_o),
        .fetch_err_i (fetch_err_i),
        .stat_o      (stat),
        .bad_op_o    (bad_op_o)
    );

    assign stat_o    = stat;
    assign next_pc_o = pc_i + ADDR_W'(len_o);

    // Cross-module consistency checks
    always_comb begin
        p_len_legal_r1: assert (len_o == LEN_W'(1) || len_o == LEN_W'(2) ||
                                len_o == LEN_W'(CONST_BYTES + 1) ||
                                len_o == LEN_W'(CONST_BYTES + 2))
            else $error("length %0d not legal", len_o);
        p_noreg_idle_r4: assert (has_reg || (ra_o == NO_REG && rb_o == NO_REG))
            else $error("register fields not idle");
        p_noconst_zero_r7: assert (len_o > LEN_W'(2) || imm_o == '0)
            else $error("constant not zero for short instruction");
        p_badop_stat_r10: assert (fetch_err_i || !bad_op_o || stat_o == 2'd3)
            else $error("invalid op without invalid status");
        p_err_prio_r11: assert (!fetch_err_i || stat_o == 2'd2)
            else $error("fetch error not reported first");
        p_fmt_len_r1: assert ((fmt == FMT_BARE) == (len_o == LEN_W'(1)))
            else $error("shape and length disagree");
    end

endmodule

// File: tb/insn_fetch_decode_bench.sv
module insn_fetch_decode_bench;

    typedef struct packed {
        logic [47:0] win;
        logic [2:0]  len;
        logic [3:0]  ra;
        logic [3:0]  rb;
        logic [31:0] imm;
        logic [1:0]  stat;
        logic        bad;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{48'h1122_3344_5500, 3'd1, 4'hF, 4'hF, 32'h0000_0000, 2'd0, 1'b0}, // nop
        '{48'hFFFF_FFFF_FF10, 3'd1, 4'hF, 4'hF, 32'h0000_0000, 2'd1, 1'b0}, // halt
        '{48'hDEAD_BEEF_4320, 3'd2, 4'h4, 4'h3, 32'h0000_0000, 2'd0, 1'b0}, // reg move
        '{48'h0000_ABCD_8230, 3'd6, 4'h8, 4'h2, 32'h0000_ABCD, 2'd0, 1'b0}, // imm load
        '{48'h0000_041C_6440, 3'd6, 4'h6, 4'h4, 32'h0000_041C, 2'd0, 1'b0}, // store
        '{48'hFFFF_FFF4_1550, 3'd6, 4'h1, 4'h5, 32'hFFFF_FFF4, 2'd0, 1'b0}, // load
        '{48'h0102_0304_2561, 3'd2, 4'h2, 4'h5, 32'h0000_0000, 2'd0, 1'b0}, // alu
        '{48'hAA00_0001_2374, 3'd5, 4'hF, 4'hF, 32'h0000_0123, 2'd0, 1'b0}, // cond jump
        '{48'h7700_0000_2880, 3'd5, 4'hF, 4'hF, 32'h0000_0028, 2'd0, 1'b0}, // call
        '{48'h5555_5555_5590, 3'd1, 4'hF, 4'hF, 32'h0000_0000, 2'd0, 1'b0}, // return
        '{48'h0000_0000_2FA0, 3'd2, 4'h2, 4'hF, 32'h0000_0000, 2'd0, 1'b0}, // push
        '{48'h9999_9999_0FB0, 3'd2, 4'h0, 4'hF, 32'h0000_0000, 2'd0, 1'b0}, // pop
        '{48'h1234_5678_9AC5, 3'd1, 4'hF, 4'hF, 32'h0000_0000, 2'd3, 1'b1}, // invalid C
        '{48'hFFFF_FFFF_FFF0, 3'd1, 4'hF, 4'hF, 32'h0000_0000, 2'd3, 1'b1}  // invalid F
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc;
    logic [47:0] win;
    logic        ferr;
    logic [3:0]  icode, ifun, ra, rb;
    logic [31:0] imm, npc;
    logic [2:0]  len;
    logic        bad;
    logic [1:0]  stat;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    insn_fetch_decode u_insn_fetch_decode (
        .pc_i (pc), .win_i (win), .fetch_err_i (ferr),
        .icode_o (icode), .ifun_o (ifun), .ra_o (ra), .rb_o (rb),
        .imm_o (imm), .len_o (len), .next_pc_o (npc),
        .bad_op_o (bad), .stat_o (stat)
    );

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] p, input logic [47:0] w, input logic e);
        @(negedge clk);
        pc = p; win = w; ferr = e;
        #2;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        pc = 32'h0; win = 48'h0; ferr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // Idle state: all-zero window decodes as a one-byte no-op
        apply(32'h0, 48'h0, 1'b0);
        check("R1 idle len", 48'(len), 48'd1);
        check("R8 idle next", 48'(npc), 48'd1);
        check("R10 idle stat", 48'(stat), 48'd0);

        for (int i = 0; i < NV; i++) begin
            logic [31:0] p;
            p = 32'h0000_0100 + 32'(i * 16);
            apply(p, VEC[i].win, 1'b0);
            check("R1 len",    48'(len),   48'(VEC[i].len));
            check("R2 icode",  48'(icode), 48'(VEC[i].win[7:4]));
            check("R2 ifun",   48'(ifun),  48'(VEC[i].win[3:0]));
            check("R3/R4 ra",  48'(ra),    48'(VEC[i].ra));
            check("R3/R4 rb",  48'(rb),    48'(VEC[i].rb));
            check("R5/R6/R7 imm", 48'(imm), 48'(VEC[i].imm));
            check("R8 next",   48'(npc),   48'(p + 32'(VEC[i].len)));
            check("R9 bad",    48'(bad),   48'(VEC[i].bad));
            check("R10 stat",  48'(stat),  48'(VEC[i].stat));
        end

        // R11: fetch error overrides halt and invalid
        apply(32'h40, 48'hFFFF_FFFF_FF10, 1'b1);
        check("R11 halt+err stat", 48'(stat), 48'd2);
        apply(32'h40, 48'h0000_0000_00D0, 1'b1);
        check("R11 bad+err stat", 48'(stat), 48'd2);
        check("R9 bad under err", 48'(bad), 48'd1);
        apply(32'h40, 48'h0000_ABCD_8230, 1'b1);
        check("R11 ok+err stat", 48'(stat), 48'd2);
        check("R6 imm under err", 48'(imm), 48'h0000_ABCD);

        // R8: wrap at top of address space
        apply(32'hFFFF_FFFE, 48'h0000_ABCD_8230, 1'b0);
        check("R8 wrap", 48'(npc), 48'h0000_0004);
        apply(32'hFFFF_FFFD, 48'h7700_0000_2880, 1'b0);
        check("R8 wrap call", 48'(npc), 48'h0000_0002);

        // R7: junk after a two-byte op never leaks into the constant
        apply(32'h0, 48'hFFFF_FFFF_FF60, 1'b0);
        check("R7 alu junk imm", 48'(imm), 48'h0);
        check("R3 alu F regs", 48'({ra, rb}), 48'hFF);

        // R5 vs R6 on the same trailing bytes
        apply(32'h0, 48'h0605_0403_0270, 1'b0);
        check("R5 jump imm", 48'(imm), 48'h0504_0302);
        apply(32'h0, 48'h0605_0403_0250, 1'b0);
        check("R6 load imm", 48'(imm), 48'h0605_0403);

        // R1 every opcode value
        for (int op = 0; op < 16; op++) begin
            logic [2:0] el;
            case (op)
                2, 6, 10, 11: el = 3'd2;
                7, 8:         el = 3'd5;
                3, 4, 5:      el = 3'd6;
                default:      el = 3'd1;
            endcase
            apply(32'h0, {40'h0, 4'(op), 4'h0}, 1'b0);
            check("R1 sweep", 48'(len), 48'(el));
            check("R9 sweep", 48'(bad), 48'(op > 11));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule